// File: doc/BRIEF.md
# Checking-Experiment Sequencer for a Four-State Mealy Machine

The block runs a fixed checking experiment against a small sequential machine that has four states, one input bit and one output bit. On a start pulse it feeds a stored 31-step input pattern into the machine under test, one bit per clock. It records the machine's response bit at the end of each step and compares it with the value that a fault-free machine would give. The pattern has three parts. The first part brings the machine to a known state. The second part walks through every state and observes it. The third part checks each transition by applying its input and then the two-step identifying pair (0 then 1). That pair gives a different output pair from each of the four states. The pattern only proves anything for a machine that is strongly connected and has such an identifying sequence.

The fault-free machine, with states A to D, behaves as follows:
- A: input 0 gives output 1 and moves to B; input 1 gives output 0 and moves to C.
- B: input 0 gives output 0 and moves to A; input 1 gives output 1 and moves to D.
- C: input 0 gives output 0 and moves to B; input 1 gives output 0 and moves to A.
- D: input 0 gives output 1 and moves to C; input 1 gives output 1 and moves to A.

The machine under test must be in state A when the first step is applied, and it advances once per cycle while `stim_valid` is high. A separate reference model of this machine (`mealy_ref`) is included so that a bench can stand in for the machine under test. It can also switch in one of three faulty variants.

Top module: `fsm_check_seq`

## Requirements
- R1: While reset is held low and after it is released, `done`, `pass`, `fail` and `stim_valid` are 0 and `fail_step` is 0.
- R2: A `start` pulse sampled while the block is idle begins a run. `stim_valid` is 1 in the cycle after that edge, and step 0 is applied in that cycle.
- R3: Each step is held for exactly one cycle while `stim_valid` is 1. The bits on `stim_bit` for steps 0 to 30, in order, are 0010011010011010100011101010101.
- R4: The response captured at the end of step k is compared with expected bit k. The expected bits for steps 0 to 30, in order, are 1000000111011111010111001101110.
- R5: If all 31 responses match, `done` and `pass` are 1 together for exactly one cycle, 32 clock edges after the start edge, and `fail` stays 0.
- R6: On the first mismatch, at step j, `done` pulses for one cycle and `fail` becomes 1 at clock edge j+2 after the start edge, with `fail_step` equal to j.
- R7: After a mismatch the run halts. `stim_valid` is 0 from the cycle in which `done` is 1, and no later response changes `fail_step`.
- R8: `fail` and `fail_step` hold their values until the next accepted `start`. The edge that accepts `start` clears `fail`.
- R9: A `start` pulse during a run, or in the cycle of a pending comparison, is ignored. The run in progress keeps its timing and its result.
- R10: `mealy_ref` begins in A after its reset and advances only when enabled. It implements the table above when its fault select is 0. Select 1 makes C under input 1 output 1. Select 2 makes D under input 0 move to A. Select 3 makes B under input 1 output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the machine under test |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run |
| stim_bit | output | 1 | Input bit applied to the machine under test |
| stim_valid | output | 1 | High while a step is being applied; the machine under test advances on it |
| resp_bit | input | 1 | Output bit of the machine under test for the current step |
| done | output | 1 | One-cycle pulse marking the end of a run |
| pass | output | 1 | One-cycle pulse with `done` when every step matched |
| fail | output | 1 | Set on the first mismatch, held until the next run |
| fail_step | output | STEP_W | Index of the first mismatching step |

## Verification
The assertions assume that `start` is only meaningful when the block is idle. They also assume that `resp_bit` is a function of the current machine state and `stim_bit` within the same cycle, as a Mealy output is. The bench keeps within these limits. It uses the reference model as the machine under test, clocks it from `stim_valid`, and resets that model to A before every run. Runs with each of the faulty variants show that the first mismatch is reported at the step the table predicts. A further run pulses `start` partway through a passing run to show that the request is ignored.

// File: rtl/fsm_check_pkg.sv
// Shared constants and types for the checking-experiment sequencer.
// Assumes the stored pattern starts with the machine under test in state A.
// Bit k of each vector belongs to step k.
package fsm_check_pkg;

    localparam int SEQ_LEN_DEF = 31;

    // Input bits applied to the machine, step 30 down to step 0.
    localparam logic [SEQ_LEN_DEF-1:0] STIM_DEF = 31'b1010_1010_1110_0010_1011_0010_1100_100;

    // Expected fault-free response bits, step 30 down to step 0.
    localparam logic [SEQ_LEN_DEF-1:0] RESP_DEF = 31'b0111_0110_0111_0101_1111_0111_0000_001;

    // State encoding of the four-state reference machine.
    typedef enum logic [1:0] {
        ST_A = 2'd0,
        ST_B = 2'd1,
        ST_C = 2'd2,
        ST_D = 2'd3
    } mstate_t;

endpackage

// File: rtl/seq_rom.sv
// Constant pattern store: returns the stimulus bit and the expected
// response bit for one step index. Indexes past the end read as 0.
module seq_rom #(
    parameter int SEQ_LEN = fsm_check_pkg::SEQ_LEN_DEF,
    parameter int STEP_W  = $clog2(SEQ_LEN),
    parameter logic [SEQ_LEN-1:0] STIM_V = fsm_check_pkg::STIM_DEF,
    parameter logic [SEQ_LEN-1:0] RESP_V = fsm_check_pkg::RESP_DEF
) (
    input  logic [STEP_W-1:0] idx,
    output logic              stim,
    output logic              expect_bit
);

    localparam logic [STEP_W:0] LEN_EXT = (STEP_W+1)'(SEQ_LEN);

    logic in_range;

    // Decode whether the index addresses a stored step.
    always_comb begin
        in_range = ({1'b0, idx} < LEN_EXT);
    end

    // Look up both bits of the addressed step.
    always_comb begin
        stim       = 1'b0;
        expect_bit = 1'b0;
        for (int i = 0; i < SEQ_LEN; i++) begin
            if (in_range && (idx == STEP_W'(i))) begin
                stim       = STIM_V[i];
                expect_bit = RESP_V[i];
            end
        end
    end

endmodule

// File: rtl/step_driver.sv
// Step counter and run control. It accepts start only when idle, walks
// the step index once per cycle and stops after the last step or when
// the comparator raises abort.
// Assumes abort is only asserted while a comparison is pending.
module step_driver #(
    parameter int SEQ_LEN = fsm_check_pkg::SEQ_LEN_DEF,
    parameter int STEP_W  = $clog2(SEQ_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tail_busy,
    input  logic              abort,
    output logic              launch,
    output logic              running,
    output logic [STEP_W-1:0] step
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_LEN - 1);

    // Accept a start request only when no run or comparison is pending.
    always_comb begin
        launch = start && !running && !tail_busy;
    end

    // Advance the step index and drop out of the run when it ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            step    <= '0;
        end else if (launch) begin
            running <= 1'b1;
            step    <= '0;
        end else if (running) begin
            if (abort || (step == LAST_STEP)) begin
                running <= 1'b0;
            end else begin
                step <= step + STEP_W'(1);
            end
        end
    end

    // R3: every step lasts exactly one cycle while the run continues.
    assert_step_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !abort && !start && (step != LAST_STEP))
            |=> (running && (step == $past(step) + STEP_W'(1))));

    // R9: a start seen during a run does not restart the count.
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start && !abort && (step != LAST_STEP))
            |=> (step != '0));

endmodule

// File: rtl/resp_cmp.sv
// Response capture and comparison. It registers the response of the step
// just applied, compares it in the following cycle, and reports the
// verdict. The first mismatch is held until the next launch.
// Assumes resp is valid at the clock edge that ends each step.
module resp_cmp #(
    parameter int SEQ_LEN = fsm_check_pkg::SEQ_LEN_DEF,
    parameter int STEP_W  = $clog2(SEQ_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              cap_en,
    input  logic              resp,
    input  logic              expect_bit,
    input  logic [STEP_W-1:0] step,
    output logic              cap_vld,
    output logic              abort,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [STEP_W-1:0] fail_step
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_LEN - 1);

    logic              cap_resp;
    logic              cap_exp;
    logic [STEP_W-1:0] cap_idx;
    logic              last_ok;

    // Register the response, its expected value and its step index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vld  <= 1'b0;
            cap_resp <= 1'b0;
            cap_exp  <= 1'b0;
            cap_idx  <= '0;
        end else begin
            cap_vld  <= cap_en && !abort;
            cap_resp <= resp;
            cap_exp  <= expect_bit;
            cap_idx  <= step;
        end
    end

    // Flag a mismatch and a clean final step.
    always_comb begin
        abort   = cap_vld && (cap_resp != cap_exp);
        last_ok = cap_vld && (cap_resp == cap_exp) && (cap_idx == LAST_STEP);
    end

    // Produce the one-cycle verdict pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            pass <= 1'b0;
        end else begin
            done <= abort || last_ok;
            pass <= last_ok;
        end
    end

    // Hold the first failure and its step until the next run begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail      <= 1'b0;
            fail_step <= '0;
        end else if (launch) begin
            fail      <= 1'b0;
            fail_step <= '0;
        end else if (abort) begin
            fail      <= 1'b1;
            fail_step <= cap_idx;
        end
    end

    // R5: the pass pulse lasts one cycle and always comes with done.
    assert_pass_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> (done && !fail) ##1 !pass);

    // R6: a mismatch always ends in a done pulse with fail set.
    assert_abort_reports_R6: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (done && fail && !pass));

    // R8: the failure record is held while no new run starts.
    assert_fail_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !launch) |=> (fail && $stable(fail_step)));

endmodule

// File: rtl/mealy_ref.sv
// Reference four-state Mealy machine with one input and one output,
// plus selectable faulty variants. It stands in for the machine under test.
// Assumes adv is high only for cycles in which x is a real step.
module mealy_ref (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       x,
    input  logic [1:0] fault_sel,
    output logic       z
);

    import fsm_check_pkg::*;

    mstate_t cur;
    mstate_t nxt;

    // Next state and output from the state table and the selected fault.
    always_comb begin
        nxt = cur;
        z   = 1'b0;
        unique case (cur)
            ST_A: begin
                nxt = x ? ST_C : ST_B;
                z   = !x;
            end
            ST_B: begin
                nxt = x ? ST_D : ST_A;
                z   = x && (fault_sel != 2'd3);
            end
            ST_C: begin
                nxt = x ? ST_A : ST_B;
                z   = x && (fault_sel == 2'd1);
            end
            ST_D: begin
                nxt = x ? ST_A : ((fault_sel == 2'd2) ? ST_A : ST_C);
                z   = 1'b1;
            end
            default: begin
                nxt = ST_A;
                z   = 1'b0;
            end
        endcase
    end

    // Hold or advance the state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= ST_A;
        end else if (adv) begin
            cur <= nxt;
        end
    end

    // R10: the state only moves when enabled.
    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(cur));

endmodule

// File: rtl/fsm_check_seq.sv
// Top of the checking-experiment sequencer: pattern store, step driver
// and response comparator. Assumes the machine under test is in state A
// when the first step is applied and advances only while stim_valid is high.
module fsm_check_seq #(
    parameter int SEQ_LEN = fsm_check_pkg::SEQ_LEN_DEF,
    parameter int STEP_W  = $clog2(SEQ_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              stim_bit,
    output logic              stim_valid,
    input  logic              resp_bit,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [STEP_W-1:0] fail_step
);

    logic              launch;
    logic              running;
    logic [STEP_W-1:0] step;
    logic              cap_vld;
    logic              abort;
    logic              rom_stim;
    logic              rom_exp;

    step_driver #(.SEQ_LEN(SEQ_LEN), .STEP_W(STEP_W)) drv_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tail_busy (cap_vld),
        .abort     (abort),
        .launch    (launch),
        .running   (running),
        .step      (step)
    );

    seq_rom #(
        .SEQ_LEN (SEQ_LEN),
        .STEP_W  (STEP_W),
        .STIM_V  (fsm_check_pkg::STIM_DEF),
        .RESP_V  (fsm_check_pkg::RESP_DEF)
    ) rom_i (
        .idx        (step),
        .stim       (rom_stim),
        .expect_bit (rom_exp)
    );

    resp_cmp #(.SEQ_LEN(SEQ_LEN), .STEP_W(STEP_W)) cmp_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .cap_en     (running),
        .resp       (resp_bit),
        .expect_bit (rom_exp),
        .step       (step),
        .cap_vld    (cap_vld),
        .abort      (abort),
        .done       (done),
        .pass       (pass),
        .fail       (fail),
        .fail_step  (fail_step)
    );

    // Drive the machine under test only during a run.
    always_comb begin
        stim_valid = running;
        stim_bit   = running && rom_stim;
    end

    // R7: once the verdict is out, no further step is applied.
    assert_halt_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !stim_valid);

    // R2: an accepted start opens a run in the next cycle.
    assert_launch_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> stim_valid);

endmodule

// File: tb/fsm_check_seq_tb_top.sv
// Directed bench: the reference machine stands in for the machine under test.
module fsm_check_seq_tb_top;

    localparam int N = 31;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       mut_rst_n = 1'b0;
    logic [1:0] fault_sel = 2'd0;
    logic       stim_bit, stim_valid, resp_bit, done, pass, fail;
    logic [4:0] fail_step;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Step order, from the requirement texts.
    int exp_in [N] = '{0,0,1,0,0,1,1,0,1,0,0,1,1,0,1,0,1,0,0,0,1,1,1,0,1,0,1,0,1,0,1};

    always #10 clk = ~clk;

    fsm_check_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .stim_bit(stim_bit), .stim_valid(stim_valid), .resp_bit(resp_bit),
        .done(done), .pass(pass), .fail(fail), .fail_step(fail_step)
    );

    mealy_ref mut_i (
        .clk(clk), .rst_n(mut_rst_n), .adv(stim_valid), .x(stim_bit),
        .fault_sel(fault_sel), .z(resp_bit)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // One run: reset the stand-in machine, start, follow to the verdict.
    task automatic do_run(input int fsel, input bit exp_pass, input int exp_idx,
                          input int mid_start_at);
        int cyc;
        int k;
        int stim_err;
        bit seen;
        logic [4:0] idx_hold;
        @(negedge clk);
        fault_sel = 2'(fsel);
        mut_rst_n = 1'b0;
        @(negedge clk);
        mut_rst_n = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(stim_valid == 1'b1, "R2 run opens after start", int'(stim_valid), 1);
        chk(fail == 1'b0, "R8 start clears fail", int'(fail), 0);
        cyc = 1; k = 0; stim_err = 0; seen = 1'b0;
        while (!seen && cyc < 80) begin
            if (done) begin
                seen = 1'b1;
            end else begin
                if (stim_valid) begin
                    if (k < N && int'(stim_bit) != exp_in[k]) stim_err++;
                    k++;
                end
                start = (cyc == mid_start_at);
                @(negedge clk);
                cyc++;
            end
        end
        start = 1'b0;
        chk(seen, "R5/R6 done seen", int'(seen), 1);
        if (exp_pass) begin
            chk(cyc == 33, "R5 pass latency", cyc, 33);
            chk(pass == 1'b1 && fail == 1'b0, "R5 verdict pass", int'(pass), 1);
            chk(k == N, "R3 step count", k, N);
            chk(stim_err == 0, "R3 stimulus bits", stim_err, 0);
            if (mid_start_at > 0)
                chk(cyc == 33 && pass, "R9 mid-run start ignored", cyc, 33);
        end else begin
            chk(cyc == exp_idx + 3, "R6 fail latency", cyc, exp_idx + 3);
            chk(fail == 1'b1 && pass == 1'b0, "R6 verdict fail", int'(fail), 1);
            chk(int'(fail_step) == exp_idx, "R4/R6 first mismatch step", int'(fail_step), exp_idx);
        end
        chk(stim_valid == 1'b0, "R7 stimulus stopped at done", int'(stim_valid), 0);
        idx_hold = fail_step;
        @(negedge clk);
        chk(done == 1'b0 && pass == 1'b0, "R5 one-cycle pulses", int'(done) + int'(pass), 0);
        repeat (4) @(negedge clk);
        chk(fail == !exp_pass, "R8 fail held", int'(fail), int'(!exp_pass));
        chk(fail_step == idx_hold && stim_valid == 1'b0, "R7 record frozen",
            int'(fail_step), int'(idx_hold));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!done && !pass && !fail && !stim_valid, "R1 outputs low in reset",
            int'(done) + int'(pass) + int'(fail) + int'(stim_valid), 0);
        rst_n = 1'b1;
        mut_rst_n = 1'b1;
        @(negedge clk);
        chk(fail_step == 5'd0 && !stim_valid && !done, "R1 state after reset",
            int'(fail_step), 0);
    endtask

    task automatic t_clean_pass();     do_run(0, 1'b1, 0, 0);   endtask
    task automatic t_output_fault_C(); do_run(1, 1'b0, 6, 0);   endtask  // R10 select 1
    task automatic t_transfer_fault(); do_run(2, 1'b0, 10, 0);  endtask  // R10 select 2
    task automatic t_output_fault_B(); do_run(3, 1'b0, 8, 0);   endtask  // R10 select 3
    task automatic t_start_mid_run();  do_run(0, 1'b1, 0, 12);  endtask  // R9

    initial begin
        t_reset();
        t_clean_pass();
        t_output_fault_C();
        t_clean_pass();
        t_transfer_fault();
        t_output_fault_B();
        t_start_mid_run();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule